// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block performs the entry step of exception handling for a 32-bit in-order pipeline. Earlier logic has already chosen which exception wins. It hands over that one request together with the faulting PC, a flag saying whether the faulting instruction sits in a branch delay slot, and a qualifier marking a TLB refill. It also supplies the present contents of the status bits, the cause register, the three return-address registers, and the user and debug mode flags.

In response, the block computes the new value of each of those registers and the address to fetch from next. There are three entry paths: general exceptions (including TLB load and store misses), error-level entries (NMI and soft reset), and debug entries. Each path has its own return register, its own vector and its own delay-slot handling.

All outputs are registered. They are loaded in the cycle after a request is sampled, and the redirect strobe is high for that one cycle. Between redirects the value outputs keep their last contents. The surrounding core writes the values back into its architectural registers while the strobe is high.

Top module: `exc_entry`

## Requirements
- R1: After reset every output is 0. `redir_vld` is high in the cycle after each edge at which `exc_vld` is sampled high with a supported kind, and low in every other cycle. Between redirects the value outputs hold their last contents, and `slot_clr` and `watch_clr` are 0.
- R2: For a general kind (0 = other, 1 = TLB load miss, 2 = TLB store miss) taken with EXL clear (`cur_stat[0]`=0), the following happen:
  - `new_epc` becomes `pc`-4 when `in_slot` is 1, and `pc` otherwise.
  - `new_cause[31]` (the delay-slot flag) becomes `in_slot`.
  - EXL is set in `new_stat` and `new_user` is 0.
- R3: For a general kind taken with EXL already set, `new_epc` and `new_cause[31]` keep their current values. EXL stays set and `new_user` is 0.
- R4: For a general kind the redirect PC is a base plus an offset.
  - The base is 0xBFC00200 when BEV (`cur_stat[2]`) is 1, and 0x80000000 otherwise.
  - The offset is 0x000 for a TLB kind with `refill`=1 and EXL clear, and 0x180 in every other case.
  - `refill` has no effect on kind 0.
- R5: For a general kind, `new_cause[6:2]` holds the code: 2 for a TLB load miss, 3 for a TLB store miss, and `exc_code` for kind 0. All other cause bits except bit 31 keep their values.
- R6: NMI (kind 3) does the following:
  - ORs the NMI flag (`cur_stat[4]`), ERL (`cur_stat[1]`) and BEV into the status.
  - Sets `new_errorepc` by the same delay-slot rule as R2.
  - Clears user mode and redirects to 0xBFC00000.
  - Leaves the cause, `new_epc`, `new_depc` and the debug flag unchanged.
- R7: Soft reset (kind 4) behaves like NMI, except that it ORs the soft-reset flag (`cur_stat[3]`) in place of the NMI flag and pulses `watch_clr` for one cycle. No other kind pulses `watch_clr`.
- R8: Debug (kind 5) does the following:
  - Sets `new_depc` by the delay-slot rule and sets `new_dbg`.
  - Clears user mode and redirects to 0xBFC00480.
  - Leaves the status, the cause, `new_epc` and `new_errorepc` unchanged.
- R9: `slot_clr` pulses with the redirect when `in_slot` was 1. The one exception is a general kind taken with EXL set, which leaves it 0.
- R10: Kinds 6 and 7 are ignored: no redirect, no pulses, and all value outputs keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_vld | input | 1 | Exception request present this cycle |
| exc_kind | input | 3 | 0 other, 1 TLB load miss, 2 TLB store miss, 3 NMI, 4 soft reset, 5 debug |
| exc_code | input | 5 | Cause code used for kind 0 |
| in_slot | input | 1 | Faulting instruction is in a delay slot |
| refill | input | 1 | TLB miss is a refill |
| pc | input | 32 | PC of the faulting instruction |
| cur_stat | input | 5 | Status: [0] EXL, [1] ERL, [2] BEV, [3] soft-reset flag, [4] NMI flag |
| cur_user | input | 1 | Currently in user mode |
| cur_dbg | input | 1 | Currently in debug mode |
| cur_cause | input | 32 | Current cause register |
| cur_epc | input | 32 | Current EPC |
| cur_errorepc | input | 32 | Current error EPC |
| cur_depc | input | 32 | Current debug EPC |
| redir_vld | output | 1 | Redirect strobe, one cycle |
| redir_pc | output | 32 | New fetch address |
| new_stat | output | 5 | Updated status bits |
| new_user | output | 1 | Updated user-mode flag |
| new_dbg | output | 1 | Updated debug-mode flag |
| new_cause | output | 32 | Updated cause register |
| new_epc | output | 32 | Updated EPC |
| new_errorepc | output | 32 | Updated error EPC |
| new_depc | output | 32 | Updated debug EPC |
| slot_clr | output | 1 | Clear the pipeline's delay-slot state |
| watch_clr | output | 1 | Clear the watch register |

## Verification
The assertions assume the request fields (`exc_kind`, `pc`, `in_slot`, `refill` and the current register values) are stable and meaningful whenever `exc_vld` is high. They also assume a request may arrive in any cycle, including back to back. The bench changes inputs only on the falling edge and holds them for a whole cycle. Its random phase draws all eight kind codes, so the reserved codes are exercised alongside every path. It mixes EXL, BEV, delay-slot and refill settings so that the refill offset, the kept EPC and the kept delay-slot flag each meet both of their conditions.

// File: rtl/exc_entry.sv
module exc_entry #(
  parameter logic [31:0] GEN_OFS   = 32'h0000_0180,
  parameter logic [31:0] BOOT_BASE = 32'hBFC0_0200,
  parameter logic [31:0] RUN_BASE  = 32'h8000_0000,
  parameter logic [31:0] ERR_VEC   = 32'hBFC0_0000,
  parameter logic [31:0] DBG_VEC   = 32'hBFC0_0480,
  parameter logic [4:0]  CODE_TLBL = 5'd2,
  parameter logic [4:0]  CODE_TLBS = 5'd3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        exc_vld,
  input  logic [2:0]  exc_kind,
  input  logic [4:0]  exc_code,
  input  logic        in_slot,
  input  logic        refill,
  input  logic [31:0] pc,
  input  logic [4:0]  cur_stat,
  input  logic        cur_user,
  input  logic        cur_dbg,
  input  logic [31:0] cur_cause,
  input  logic [31:0] cur_epc,
  input  logic [31:0] cur_errorepc,
  input  logic [31:0] cur_depc,
  output logic        redir_vld,
  output logic [31:0] redir_pc,
  output logic [4:0]  new_stat,
  output logic        new_user,
  output logic        new_dbg,
  output logic [31:0] new_cause,
  output logic [31:0] new_epc,
  output logic [31:0] new_errorepc,
  output logic [31:0] new_depc,
  output logic        slot_clr,
  output logic        watch_clr
);
  localparam int EXL = 0, ERL = 1, BEV = 2, SRF = 3, NMF = 4, BD = 31;
  localparam logic [2:0] K_GEN = 3'd0, K_TLBL = 3'd1, K_TLBS = 3'd2,
                         K_NMI = 3'd3, K_SRST = 3'd4, K_DBG = 3'd5;

  logic        general, tlb, take;
  logic [31:0] ret_pc, base, ofs;
  logic [4:0]  code;

  assign general = exc_kind <= K_TLBS;
  assign tlb     = (exc_kind == K_TLBL) || (exc_kind == K_TLBS);
  assign take    = exc_vld && (exc_kind <= K_DBG);
  assign ret_pc  = in_slot ? pc - 32'd4 : pc;
  assign base    = cur_stat[BEV] ? BOOT_BASE : RUN_BASE;
  assign ofs     = (tlb && refill && !cur_stat[EXL]) ? 32'd0 : GEN_OFS;
  assign code    = (exc_kind == K_TLBL) ? CODE_TLBL :
                   (exc_kind == K_TLBS) ? CODE_TLBS : exc_code;

  logic [31:0] n_pc, n_cause, n_epc, n_errorepc, n_depc;
  logic [4:0]  n_stat;
  logic        n_user, n_dbg, n_sc;

  always_comb begin
    n_pc       = ERR_VEC;
    n_stat     = cur_stat;
    n_user     = 1'b0;
    n_dbg      = cur_dbg;
    n_cause    = cur_cause;
    n_epc      = cur_epc;
    n_errorepc = cur_errorepc;
    n_depc     = cur_depc;
    n_sc       = in_slot;
    if (general) begin
      if (!cur_stat[EXL]) begin
        n_epc       = ret_pc;
        n_cause[BD] = in_slot;
      end else begin
        n_sc = 1'b0;
      end
      n_stat[EXL]    = 1'b1;
      n_cause[6:2]   = code;
      n_pc           = base + ofs;
    end else if (exc_kind == K_DBG) begin
      n_depc = ret_pc;
      n_dbg  = 1'b1;
      n_pc   = DBG_VEC;
    end else begin
      n_errorepc  = ret_pc;
      n_stat[ERL] = 1'b1;
      n_stat[BEV] = 1'b1;
      if (exc_kind == K_NMI) n_stat[NMF] = 1'b1;
      else                   n_stat[SRF] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redir_vld    <= 1'b0;
      redir_pc     <= '0;
      new_stat     <= '0;
      new_user     <= 1'b0;
      new_dbg      <= 1'b0;
      new_cause    <= '0;
      new_epc      <= '0;
      new_errorepc <= '0;
      new_depc     <= '0;
      slot_clr     <= 1'b0;
      watch_clr    <= 1'b0;
    end else begin
      redir_vld <= take;
      slot_clr  <= take && n_sc;
      watch_clr <= take && (exc_kind == K_SRST);
      if (take) begin
        redir_pc     <= n_pc;
        new_stat     <= n_stat;
        new_user     <= n_user && cur_user;
        new_dbg      <= n_dbg;
        new_cause    <= n_cause;
        new_epc      <= n_epc;
        new_errorepc <= n_errorepc;
        new_depc     <= n_depc;
      end
    end
  end

  p_redirect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_vld && exc_kind <= K_DBG) |=> redir_vld);
  p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_vld && exc_kind <= K_DBG) |=> !redir_vld && !watch_clr && !slot_clr && $stable(redir_pc));
  p_exl_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_vld && exc_kind <= K_TLBS) |=> new_stat[EXL] && !new_user);
  p_epc_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_vld && exc_kind <= K_TLBS && cur_stat[EXL]) |=>
      new_epc == $past(cur_epc) && new_cause[BD] == $past(cur_cause[BD]) && !slot_clr);
  p_tlbl_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_vld && exc_kind == K_TLBL) |=> new_cause[6:2] == CODE_TLBL);
  p_err_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_vld && (exc_kind == K_NMI || exc_kind == K_SRST)) |=>
      redir_pc == ERR_VEC && new_stat[ERL] && new_stat[BEV] && new_cause == $past(cur_cause));
  p_watch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_vld && exc_kind != K_SRST) |=> !watch_clr);
  p_dbg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_vld && exc_kind == K_DBG) |=> new_dbg && !new_user && redir_pc == DBG_VEC);
endmodule

// File: tb/exc_entry_test.sv
module exc_entry_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        exc_vld = 0, in_slot = 0, refill = 0, cur_user = 0, cur_dbg = 0;
  logic [2:0]  exc_kind = 0;
  logic [4:0]  exc_code = 0, cur_stat = 0;
  logic [31:0] pc = 0, cur_cause = 0, cur_epc = 0, cur_errorepc = 0, cur_depc = 0;
  logic        redir_vld, new_user, new_dbg, slot_clr, watch_clr;
  logic [31:0] redir_pc, new_cause, new_epc, new_errorepc, new_depc;
  logic [4:0]  new_stat;

  exc_entry uut (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  logic        m_vld, m_user, m_dbg, m_sc, m_wc;
  logic [31:0] m_pc, m_cause, m_epc, m_eepc, m_depc;
  logic [4:0]  m_stat;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "redir_vld", 32'(redir_vld), 32'(m_vld));
    chk(tag, "redir_pc", redir_pc, m_pc);
    chk(tag, "new_stat", 32'(new_stat), 32'(m_stat));
    chk(tag, "new_user", 32'(new_user), 32'(m_user));
    chk(tag, "new_dbg", 32'(new_dbg), 32'(m_dbg));
    chk(tag, "new_cause", new_cause, m_cause);
    chk(tag, "new_epc", new_epc, m_epc);
    chk(tag, "new_errorepc", new_errorepc, m_eepc);
    chk(tag, "new_depc", new_depc, m_depc);
    chk(tag, "slot_clr", 32'(slot_clr), 32'(m_sc));
    chk(tag, "watch_clr", 32'(watch_clr), 32'(m_wc));
  endtask

  task automatic model();
    logic [31:0] back;
    int code;
    back = in_slot ? pc - 4 : pc;
    m_sc = 0; m_wc = 0; m_vld = 0;
    if (!exc_vld || exc_kind > 5) return;
    m_vld = 1; m_user = 0; m_dbg = cur_dbg; m_stat = cur_stat;
    m_cause = cur_cause; m_epc = cur_epc; m_eepc = cur_errorepc; m_depc = cur_depc;
    if (exc_kind <= 2) begin
      code = (exc_kind == 1) ? 2 : (exc_kind == 2) ? 3 : int'(exc_code);
      if (cur_stat[0] == 0) begin
        m_epc = back; m_cause[31] = in_slot; m_sc = in_slot;
      end
      m_stat[0] = 1;
      m_cause[6:2] = code[4:0];
      m_pc = (cur_stat[2] ? 32'hBFC00200 : 32'h80000000) +
             ((exc_kind != 0 && refill && cur_stat[0] == 0) ? 32'h0 : 32'h180);
    end else if (exc_kind == 5) begin
      m_depc = back; m_dbg = 1; m_sc = in_slot; m_pc = 32'hBFC00480;
    end else begin
      m_eepc = back; m_sc = in_slot; m_pc = 32'hBFC00000;
      m_stat = m_stat | 5'b00110 | (exc_kind == 3 ? 5'b10000 : 5'b01000);
      m_wc = (exc_kind == 4);
    end
  endtask

  task automatic step(string tag, bit v, logic [2:0] k, logic [4:0] st, bit slot, bit rf,
                      logic [31:0] p);
    exc_vld = v; exc_kind = k; cur_stat = st; in_slot = slot; refill = rf; pc = p;
    model();
    @(posedge clk); @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    m_vld = 0; m_pc = 0; m_stat = 0; m_user = 0; m_dbg = 0; m_cause = 0;
    m_epc = 0; m_eepc = 0; m_depc = 0; m_sc = 0; m_wc = 0;
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1;
    cur_user = 1; cur_cause = 32'h0000_FF80; cur_epc = 32'h1111_1110;
    cur_errorepc = 32'h2222_2220; cur_depc = 32'h3333_3330; exc_code = 5'd12;
    step("R1 idle", 0, 0, 5'b00000, 0, 0, 32'h400);
    step("R2 R4 R5 general bev1", 1, 0, 5'b00100, 0, 0, 32'h0040_1000);
    step("R1 hold", 0, 0, 5'b00100, 0, 0, 32'h0);
    step("R2 R4 R9 slot bev0", 1, 0, 5'b00000, 1, 0, 32'h0040_2008);
    cur_cause = 32'h8000_0004;
    step("R3 exl set keeps epc/bd", 1, 0, 5'b00001, 0, 0, 32'h0040_3000);
    step("R3 R9 exl slot", 1, 0, 5'b00001, 1, 0, 32'h0040_3004);
    cur_cause = 32'h0000_0000;
    step("R4 R5 tlbl refill exl0", 1, 1, 5'b00000, 0, 1, 32'h0000_5000);
    step("R4 tlbs refill exl1", 1, 2, 5'b00001, 0, 1, 32'h0000_6000);
    step("R4 tlbl nonrefill bev1", 1, 1, 5'b00100, 1, 0, 32'h0000_7004);
    step("R4 refill ignored kind0", 1, 0, 5'b00000, 0, 1, 32'h0000_8000);
    step("R5 tlbs code", 1, 2, 5'b00000, 0, 0, 32'h0000_9000);
    cur_cause = 32'h8000_0000;
    step("R6 nmi slot", 1, 3, 5'b00001, 1, 0, 32'hA000_0010);
    step("R7 soft reset", 1, 4, 5'b00000, 0, 0, 32'hA000_0020);
    step("R7 watch pulse ends", 0, 0, 5'b00000, 0, 0, 32'h0);
    cur_dbg = 0;
    step("R8 debug slot", 1, 5, 5'b10101, 1, 0, 32'hA000_0104);
    step("R8 debug noslot", 1, 5, 5'b00000, 0, 0, 32'hA000_0200);
    step("R10 kind6", 1, 6, 5'b00000, 1, 1, 32'hDEAD_0000);
    step("R10 kind7", 1, 7, 5'b00001, 1, 0, 32'hDEAD_0004);
    step("R1 back to back a", 1, 3, 5'b00000, 0, 0, 32'h0000_1234);
    step("R1 back to back b", 1, 0, 5'b00000, 0, 0, 32'h0000_5678);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      cur_user = r[20]; cur_dbg = r[21]; exc_code = r[26:22];
      cur_cause = $urandom; cur_epc = $urandom; cur_errorepc = $urandom; cur_depc = $urandom;
      step("mixed", r[0] | r[1], r[4:2], r[9:5], r[10], r[11], {r[31:12], r[11:0]});
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule